// File: doc/BRIEF.md
# Interrupt-Capable General-Purpose Pin Controller

This block controls a bank of general-purpose pins through an APB slave port. Software sets each pin's direction and output value and reads back the sampled input levels. Each pin can also report an interrupt condition. There are four conditions to choose from: high level, low level, rising edge and falling edge. Two per-pin selector vectors pick the condition. A pin records its condition in a per-pin status bit only when that pin's enable bit is set. One interrupt line is high whenever any status bit is set. Reading the status word returns the captured bits and clears them, and this lowers the interrupt line.

Eight further words are plain storage. Their contents go straight to an output bus that the pad cells decode. The pin inputs are asynchronous to the bus clock, so they pass through a two-stage synchronizer before any logic uses them. Edges are found by comparing each synchronized sample with the sample from the cycle before. The APB port has no wait states (`pready` is held at 1). Its control pins are plain, and there is no back-pressure.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset, every register reads 0, and `pin_oe`, `pin_out`, `padcfg_o` and `irq_o` are all 0.
- R2: The word at byte offset 0x00 holds the direction of each pin and drives `pin_oe`. A bit of 1 makes that pin an output and 0 makes it an input. The new value appears on the cycle after the write access.
- R3: The word at byte offset 0x08 holds the output levels and drives `pin_out`.
- R4: The word at byte offset 0x04 returns `pin_in` after two synchronizer flops. A level applied before clock edge k can be read in any read access whose access phase comes after edge k+1.
- R5: The trigger of bit i is selected by bit i of the word at 0x10 (sel0) and bit i of the word at 0x14 (sel1). The encodings, written as (sel0, sel1), are:
  - (0,0): level high.
  - (1,0): level low.
  - (0,1): rising edge.
  - (1,1): falling edge.
  A condition sets the status bit 3 clock edges after the pin change.
- R6: A pin sets its status bit only while its bit in the enable word at 0x0C is 1.
- R7: A read of offset 0x18 returns the status bits and clears them. `irq_o` is high exactly while any status bit is set, and it falls after the edge that completes the read, unless a new condition arrives at that same edge.
- R8: If a condition is present in the same cycle as a status read, its status bit stays set after the read. A persisting level condition therefore keeps its bit and `irq_o` set.
- R9: The eight words at byte offsets 0x20 + 4*i (i = 0..7) can be read and written. Word i drives `padcfg_o[32*i+31 : 32*i]` and has no other effect.
- R10: Writes to the input word (0x04), the status word (0x18) and unmapped offsets have no effect. Reads of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus and core clock |
| presetn | input | 1 | Active-low synchronous reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write (1) or read (0) |
| paddr | input | 12 | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | Always 1, no wait states |
| pin_in | input | 32 | Asynchronous pin levels |
| pin_out | output | 32 | Pin output levels |
| pin_oe | output | 32 | Pin output enables (1 = output) |
| padcfg_o | output | 256 | Eight pad configuration words |
| irq_o | output | 1 | Shared interrupt |

## Verification
A pin change that the bench applies at a falling edge reaches the input word after two rising edges. It sets a status bit on the third rising edge. `irq_o` drops on the rising edge that completes a status read.

The bench keeps a cycle model of the synchronizer, the previous sample and the status bits. It updates this model on every rising edge from the requirements. Read data is sampled mid-cycle in the access phase, and `irq_o` is sampled at the falling edge that follows the access. Directed cases wait at least four edges after a pin change before reading, so each result has settled.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  // Word indices (byte offset / 4) of the register map
  localparam int IDX_DIR  = 0;
  localparam int IDX_IN   = 1;
  localparam int IDX_OUT  = 2;
  localparam int IDX_EN   = 3;
  localparam int IDX_SEL0 = 4;
  localparam int IDX_SEL1 = 5;
  localparam int IDX_STAT = 6;
  localparam int IDX_CFG0 = 8;

  // Trigger select, packed as {sel1, sel0}
  typedef enum logic [1:0] {
    TRIG_LVL_HI = 2'b00,
    TRIG_LVL_LO = 2'b01,
    TRIG_RISE   = 2'b10,
    TRIG_FALL   = 2'b11
  } trig_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (!rst_n) stage_q[s] <= '0;
        else if (s == 0) stage_q[s] <= d;
        else stage_q[s] <= stage_q[(s > 0) ? s - 1 : 0];
      end
    end
  endgenerate

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_trig.sv
module gpio_trig
  import gpio_irq_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cur,
  input  logic [W-1:0] prev,
  input  logic [W-1:0] en,
  input  logic [W-1:0] sel0,
  input  logic [W-1:0] sel1,
  output logic [W-1:0] hit
);
  generate
    for (genvar i = 0; i < W; i++) begin : g_pin
      trig_e mode;
      logic  cond;
      assign mode = trig_e'({sel1[i], sel0[i]});
      always_comb begin
        unique case (mode)
          TRIG_LVL_HI: cond = cur[i];
          TRIG_LVL_LO: cond = ~cur[i];
          TRIG_RISE:   cond = cur[i] & ~prev[i];
          TRIG_FALL:   cond = ~cur[i] & prev[i];
          default:     cond = 1'b0;
        endcase
      end
      assign hit[i] = cond & en[i];
    end
  endgenerate

  // R5: an edge-mode hit needs a change between the two samples
  assert_edge_needs_change_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((hit & sel1 & ~(cur ^ prev)) == '0));
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int NPIN   = 32,
  parameter int NCFG   = 8,
  parameter int ADDR_W = 12
) (
  input  logic               pclk,
  input  logic               presetn,
  input  logic               psel,
  input  logic               penable,
  input  logic               pwrite,
  input  logic [ADDR_W-1:0]  paddr,
  input  logic [31:0]        pwdata,
  output logic [31:0]        prdata,
  output logic               pready,
  input  logic [NPIN-1:0]    pin_in,
  output logic [NPIN-1:0]    pin_out,
  output logic [NPIN-1:0]    pin_oe,
  output logic [NCFG*32-1:0] padcfg_o,
  output logic               irq_o
);
  localparam int WIDX_W = ADDR_W - 2;

  logic [WIDX_W-1:0] widx;
  logic              acc, wr_acc, rd_stat;
  logic [NPIN-1:0]   dir_q, out_q, en_q, sel0_q, sel1_q, stat_q;
  logic [NPIN-1:0]   sync_q, prev_q, hit;
  logic [31:0]       cfg_q [NCFG];
  logic [31:0]       rd_word;

  assign widx    = paddr[ADDR_W-1:2];
  assign acc     = psel & penable;
  assign wr_acc  = acc & pwrite;
  assign rd_stat = acc & ~pwrite & (int'(widx) == IDX_STAT);
  assign pready  = 1'b1;

  gpio_sync #(.W(NPIN), .STAGES(2)) u_sync (
    .clk(pclk), .rst_n(presetn), .d(pin_in), .q(sync_q)
  );

  always_ff @(posedge pclk) begin
    if (!presetn) prev_q <= '0;
    else          prev_q <= sync_q;
  end

  gpio_trig #(.W(NPIN)) u_trig (
    .clk(pclk), .rst_n(presetn), .cur(sync_q), .prev(prev_q),
    .en(en_q), .sel0(sel0_q), .sel1(sel1_q), .hit(hit)
  );

  // Control words
  always_ff @(posedge pclk) begin
    if (!presetn) begin
      dir_q  <= '0;
      out_q  <= '0;
      en_q   <= '0;
      sel0_q <= '0;
      sel1_q <= '0;
    end else if (wr_acc) begin
      if (int'(widx) == IDX_DIR)  dir_q  <= pwdata[NPIN-1:0];
      if (int'(widx) == IDX_OUT)  out_q  <= pwdata[NPIN-1:0];
      if (int'(widx) == IDX_EN)   en_q   <= pwdata[NPIN-1:0];
      if (int'(widx) == IDX_SEL0) sel0_q <= pwdata[NPIN-1:0];
      if (int'(widx) == IDX_SEL1) sel1_q <= pwdata[NPIN-1:0];
    end
  end

  // Status capture: a read clears, a concurrent hit survives
  always_ff @(posedge pclk) begin
    if (!presetn) stat_q <= '0;
    else          stat_q <= (rd_stat ? '0 : stat_q) | hit;
  end

  // Pad configuration storage
  generate
    for (genvar c = 0; c < NCFG; c++) begin : g_cfg
      always_ff @(posedge pclk) begin
        if (!presetn) cfg_q[c] <= '0;
        else if (wr_acc && int'(widx) == IDX_CFG0 + c) cfg_q[c] <= pwdata;
      end
      assign padcfg_o[32*c +: 32] = cfg_q[c];
    end
  endgenerate

  // Read mux
  always_comb begin
    rd_word = '0;
    if (int'(widx) == IDX_DIR)  rd_word[NPIN-1:0] = dir_q;
    if (int'(widx) == IDX_IN)   rd_word[NPIN-1:0] = sync_q;
    if (int'(widx) == IDX_OUT)  rd_word[NPIN-1:0] = out_q;
    if (int'(widx) == IDX_EN)   rd_word[NPIN-1:0] = en_q;
    if (int'(widx) == IDX_SEL0) rd_word[NPIN-1:0] = sel0_q;
    if (int'(widx) == IDX_SEL1) rd_word[NPIN-1:0] = sel1_q;
    if (int'(widx) == IDX_STAT) rd_word[NPIN-1:0] = stat_q;
    for (int c = 0; c < NCFG; c++)
      if (int'(widx) == IDX_CFG0 + c) rd_word = cfg_q[c];
  end

  assign prdata  = rd_word;
  assign pin_out = out_q;
  assign pin_oe  = dir_q;
  assign irq_o   = |stat_q;

  // R2: a direction write shows on pin_oe one cycle later
  assert_dir_write_R2: assert property (@(posedge pclk) disable iff (!presetn)
    (wr_acc && int'(widx) == IDX_DIR) |=> (pin_oe == $past(pwdata[NPIN-1:0])));

  // R6: no status bit rises for a pin that was disabled
  assert_status_needs_enable_R6: assert property (@(posedge pclk) disable iff (!presetn)
    1'b1 |=> ((stat_q & ~$past(stat_q) & ~$past(en_q)) == '0));

  // R7: a status read with no new hit drops the interrupt
  assert_read_drops_irq_R7: assert property (@(posedge pclk) disable iff (!presetn)
    (rd_stat && hit == '0) |=> !irq_o);

  // R8: any hit, read or not, leaves the interrupt high next cycle
  assert_hit_keeps_irq_R8: assert property (@(posedge pclk) disable iff (!presetn)
    (|hit) |=> irq_o);
endmodule

// File: tb/sim_gpio_irq_ctrl.sv
`timescale 1ns/1ps
module sim_gpio_irq_ctrl;
  logic         clk = 1'b0;
  logic         presetn = 1'b0;
  logic         psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [11:0]  paddr = '0;
  logic [31:0]  pwdata = '0;
  logic [31:0]  prdata;
  logic         pready;
  logic [31:0]  pin_in = '0;
  logic [31:0]  pin_out, pin_oe;
  logic [255:0] padcfg_o;
  logic         irq_o;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  // Bench shadow of the trigger configuration
  logic [31:0] sh_en = '0, sh_s0 = '0, sh_s1 = '0;
  // Cycle model state
  logic [31:0] m_s1, m_s2, m_prev, m_stat;

  always #2.5 clk = ~clk;

  gpio_irq_ctrl u0 (
    .pclk(clk), .presetn(presetn), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .pready(pready), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .padcfg_o(padcfg_o), .irq_o(irq_o)
  );

  function automatic logic [31:0] f_hit(input logic [31:0] cur, prev, en, s0, s1);
    logic [31:0] h;
    for (int i = 0; i < 32; i++) begin
      case ({s1[i], s0[i]})
        2'b00:   h[i] = cur[i];
        2'b01:   h[i] = ~cur[i];
        2'b10:   h[i] = cur[i] & ~prev[i];
        default: h[i] = ~cur[i] & prev[i];
      endcase
    end
    return h & en;
  endfunction

  always @(posedge clk) begin
    if (!presetn) begin
      m_s1 <= '0; m_s2 <= '0; m_prev <= '0; m_stat <= '0;
    end else begin
      m_s1   <= pin_in;
      m_s2   <= m_s1;
      m_prev <= m_s2;
      m_stat <= ((psel && penable && !pwrite && paddr == 12'h018) ? 32'h0 : m_stat)
                | f_hit(m_s2, m_prev, sh_en, sh_s0, sh_s1);
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apb_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
    if (a == 12'h00C) sh_en = d;
    if (a == 12'h010) sh_s0 = d;
    if (a == 12'h014) sh_s1 = d;
  endtask

  task automatic apb_rd(input logic [11:0] a, output logic [31:0] got,
                        output logic [31:0] snap_stat, output logic [31:0] snap_in);
    @(negedge clk); psel = 1; penable = 0; pwrite = 0; paddr = a;
    @(negedge clk); penable = 1;
    #1; got = prdata; snap_stat = m_stat; snap_in = m_s2;
    @(negedge clk); psel = 0; penable = 0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] got, ss, si, pat;
    int unused_seed;
    unused_seed = $urandom(32'h5EED);
    idle(4);
    presetn = 1'b1;
    idle(1);

    // R1: reset state
    chk("R1 pin_oe", pin_oe, 32'h0);
    chk("R1 pin_out", pin_out, 32'h0);
    chk("R1 padcfg", padcfg_o[31:0] | padcfg_o[255:224], 32'h0);
    chk("R1 irq", {31'h0, irq_o}, 32'h0);
    apb_rd(12'h018, got, ss, si); chk("R1 status", got, 32'h0);
    apb_rd(12'h000, got, ss, si); chk("R1 dir", got, 32'h0);

    // R2 / R3
    apb_wr(12'h000, 32'hA5A5_0F0F);
    chk("R2 pin_oe", pin_oe, 32'hA5A5_0F0F);
    apb_rd(12'h000, got, ss, si); chk("R2 readback", got, 32'hA5A5_0F0F);
    apb_wr(12'h008, 32'h1234_5678);
    chk("R3 pin_out", pin_out, 32'h1234_5678);
    apb_rd(12'h008, got, ss, si); chk("R3 readback", got, 32'h1234_5678);

    // R9: pad configuration words
    for (int c = 0; c < 8; c++) apb_wr(12'h020 + 12'(4*c), 32'hC0DE_0000 + 32'(c));
    for (int c = 0; c < 8; c++) begin
      chk("R9 padcfg_o", padcfg_o[32*c +: 32], 32'hC0DE_0000 + 32'(c));
      apb_rd(12'h020 + 12'(4*c), got, ss, si); chk("R9 readback", got, 32'hC0DE_0000 + 32'(c));
    end

    // R4: synchronized input, then R10 write ignored
    pin_in = 32'h00F0_0F00; idle(3);
    apb_rd(12'h004, got, ss, si); chk("R4 input", got, 32'h00F0_0F00);
    apb_wr(12'h004, 32'hFFFF_FFFF);
    apb_rd(12'h004, got, ss, si); chk("R10 input write ignored", got, 32'h00F0_0F00);
    pin_in = 32'h0; idle(4);

    // R10: status write, unmapped access
    apb_wr(12'h018, 32'hFFFF_FFFF);
    chk("R10 status write irq", {31'h0, irq_o}, 32'h0);
    apb_rd(12'h018, got, ss, si); chk("R10 status write", got, 32'h0);
    apb_wr(12'h01C, 32'hDEAD_BEEF);
    apb_rd(12'h01C, got, ss, si); chk("R10 unmapped read", got, 32'h0);
    apb_rd(12'h000, got, ss, si); chk("R10 unmapped write", got, 32'hA5A5_0F0F);

    // R6: disabled pin does not capture (level high, en=0)
    pin_in = 32'h1; idle(4);
    apb_rd(12'h018, got, ss, si); chk("R6 disabled", got, 32'h0);
    pin_in = 32'h0; idle(4);

    // R5 rising edge
    apb_wr(12'h014, 32'h1);
    apb_wr(12'h00C, 32'h1);
    idle(4);
    apb_rd(12'h018, got, ss, si); chk("R5 rise idle", got, 32'h0);
    pin_in = 32'h1; idle(4);
    chk("R7 irq set", {31'h0, irq_o}, 32'h1);
    apb_rd(12'h018, got, ss, si); chk("R5 rise", got, 32'h1);
    chk("R7 irq drops", {31'h0, irq_o}, 32'h0);
    idle(4);
    apb_rd(12'h018, got, ss, si); chk("R5 rise once", got, 32'h0);

    // R5 falling edge
    apb_wr(12'h010, 32'h1);
    pin_in = 32'h0; idle(4);
    apb_rd(12'h018, got, ss, si); chk("R5 fall", got, 32'h1);

    // R5 level low, R8 persists through read
    apb_wr(12'h014, 32'h0);
    idle(2);
    apb_rd(12'h018, got, ss, si); chk("R5 level low", got, 32'h1);
    chk("R8 irq kept", {31'h0, irq_o}, 32'h1);
    apb_rd(12'h018, got, ss, si); chk("R8 re-set", got, 32'h1);
    pin_in = 32'h1; idle(4);
    apb_rd(12'h018, got, ss, si); chk("R5 level low tail", got, 32'h1);
    chk("R7 irq after tail", {31'h0, irq_o}, 32'h0);

    // R5 level high
    apb_wr(12'h010, 32'h0);
    idle(2);
    apb_rd(12'h018, got, ss, si); chk("R5 level high", got, 32'h1);
    chk("R8 irq kept hi", {31'h0, irq_o}, 32'h1);
    pin_in = 32'h0; idle(4);
    apb_rd(12'h018, got, ss, si); chk("R5 level high tail", got, 32'h1);
    apb_rd(12'h018, got, ss, si); chk("R7 cleared", got, 32'h0);

    // Random mix against the cycle model (R5, R6, R7, R8)
    for (int it = 0; it < 300; it++) begin
      if (it % 16 == 0) begin
        apb_wr(12'h00C, $urandom);
        apb_wr(12'h010, $urandom);
        apb_wr(12'h014, $urandom);
      end
      pat = $urandom & $urandom;
      pin_in = pin_in ^ pat;
      idle(int'($urandom % 5));
      apb_rd(12'h018, got, ss, si);
      chk("R5/R6 random status", got, ss);
      chk("R7/R8 random irq", {31'h0, irq_o}, {31'h0, |m_stat});
      if (it % 25 == 0) begin
        apb_rd(12'h004, got, ss, si);
        chk("R4 random input", got, si);
      end
    end

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule